// File: doc/BRIEF.md
# Double-Buffered Bulk OUT Endpoint Receive Buffer

This block holds received data for one bulk OUT endpoint of a USB device. It has two packet slots of `DEPTH` bytes each (64 by default) used in ping-pong order. The serial engine reports each OUT token on `tok_out` and gets an ACK or NAK answer in the same cycle. A token is answered with ACK only when the next slot in rotation is free. After an ACK, the engine streams the packet bytes with `rx_wr`. It then either commits the packet with `rx_eop` or discards it with `rx_abort`.

On the bus side, a processor or DMA engine drains the data one byte per `rd_pop`. The read port always shows the oldest unread byte of the oldest committed packet. A slot becomes free again only when its last byte has been popped. A committed packet raises a service request while it is waiting. The request appears on `irq` or on `dma_req`, depending on `svc_dma_sel`.

A packet longer than `DEPTH` bytes is dropped and sets a sticky overflow flag. Reset is synchronous and active high.

Top module: `bulk_out_pingpong`

## Requirements
- R1: In the cycle after a synchronous reset:
  - `pkt_avail`, `irq`, `dma_req` and `ovf_flag` are 0.
  - `rd_byte` and `rd_remain` are 0.
  - The next OUT token is answered with ACK.
- R2: An OUT token that arrives while the slot next in rotation is free, with no packet in progress, is answered with `tok_ack`=1 and `tok_nak`=0 in that same cycle. Exactly one of the two answer outputs is high whenever `tok_out` is high.
- R3: An OUT token that arrives while both slots hold committed packets is answered with `tok_nak`=1. NAK keeps being given to every later token until the read side has popped the last byte of a slot.
- R4: In the cycle after `rx_eop` ends an accepted packet, `pkt_avail` is 1. The service request (`irq` or `dma_req`) is high exactly when `pkt_avail` is 1.
- R5: With `svc_dma_sel`=0 the service request appears on `irq`, and `dma_req` stays 0. With `svc_dma_sel`=1 it appears on `dma_req`, and `irq` stays 0.
- R6: `rd_byte` shows the oldest unread byte of the oldest committed packet. Each `rd_pop` advances by one byte. Packets are delivered in the order they were committed.
- R7: `rd_remain` equals the committed length of the current packet minus the bytes already popped from it. A slot is released, and reading moves to the other slot, only on the pop of its last byte. A committed zero-length packet is released by one pop. `pkt_avail` stays 1 while no pop occurs.
- R8: The byte after the `DEPTH`-th byte of a packet sets `ovf_flag`, which stays 1 until reset. The packet is discarded, and its remaining bytes and its `rx_eop` have no effect.
- R9: `rx_abort` during an accepted packet discards it. The slot is free again, and the next accepted packet is the one delivered.
- R10: With no committed packet, `rd_byte` and `rd_remain` read 0. An `rd_pop` then changes nothing: the next packet is read from its first byte.
- R11: `rx_wr`, `rx_eop` and `rx_abort` have no effect when no packet was accepted by an ACK. This includes bytes sent after a NAK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| svc_dma_sel | input | 1 | 1 routes the service request to `dma_req`, 0 to `irq` |
| tok_out | input | 1 | OUT token received for this endpoint (one-cycle strobe) |
| tok_ack | output | 1 | Combinational answer: accept the packet |
| tok_nak | output | 1 | Combinational answer: refuse the packet |
| rx_wr | input | 1 | Received byte strobe |
| rx_byte | input | DATA_W | Received byte |
| rx_eop | input | 1 | End of packet, commits the packet in progress |
| rx_abort | input | 1 | Packet ended badly, discards the packet in progress |
| rd_pop | input | 1 | Consume the byte shown on `rd_byte` |
| rd_byte | output | DATA_W | Oldest unread byte, 0 when nothing is committed |
| rd_remain | output | $clog2(DEPTH+1) | Unread bytes of the current packet |
| pkt_avail | output | 1 | A committed packet is waiting |
| irq | output | 1 | Service request, interrupt form |
| dma_req | output | 1 | Service request, DMA form |
| ovf_flag | output | 1 | Sticky packet-overflow flag |

## Verification
The assertions rely on three assumptions about the receive-side strobes:
- `rx_wr`, `rx_eop` and `rx_abort` are mutually exclusive.
- A token is never given while a packet is still being received.
- The bytes of a packet follow its ACKed token.

The bench drives each packet as a complete token, byte and end sequence from one task, so these conditions always hold. Pops are issued only between packets. Random packet lengths cover zero, full and oversize packets, and the random pop bursts drain partially, exactly or beyond the committed data.

// File: rtl/bop_pkg.sv
package bop_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_FILL = 2'd1,
        SLOT_FULL = 2'd2
    } slot_state_e;

    localparam int NUM_SLOTS = 2;
endpackage

// File: rtl/bop_slot_mem.sv
// One packet slot: register array with a write port and an asynchronous read.
module bop_slot_mem #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DEPTH-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/bop_rx_ctrl.sv
// Receive side: token answer, byte placement, commit, abort and overflow.
module bop_rx_ctrl #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tok_out,
    input  logic              rx_wr,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_eop,
    input  logic              rx_abort,
    input  logic              tgt_free,
    output logic              tok_ack,
    output logic              tok_nak,
    output logic              wr_sel,
    output logic              claim,
    output logic              commit,
    output logic              drop,
    output logic [CNT_W-1:0]  commit_len,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              ovf_flag
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    typedef struct packed {
        logic             active;
        logic             sel;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        tok_ack = 1'b0;
        tok_nak = 1'b0;
        claim   = 1'b0;
        commit  = 1'b0;
        drop    = 1'b0;
        mem_we  = 1'b0;

        if (tok_out) begin
            if (!st_q.active && tgt_free) begin
                tok_ack     = 1'b1;
                claim       = 1'b1;
                st_d.active = 1'b1;
                st_d.cnt    = '0;
            end else begin
                tok_nak = 1'b1;
            end
        end else if (st_q.active) begin
            if (rx_abort) begin
                drop        = 1'b1;
                st_d.active = 1'b0;
            end else if (rx_eop) begin
                commit      = 1'b1;
                st_d.active = 1'b0;
                st_d.sel    = ~st_q.sel;
            end else if (rx_wr) begin
                if (st_q.cnt == FULL_CNT) begin
                    drop        = 1'b1;
                    st_d.active = 1'b0;
                    st_d.ovf    = 1'b1;
                end else begin
                    mem_we   = 1'b1;
                    st_d.cnt = st_q.cnt + ONE_CNT;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_sel     = st_q.sel;
    assign commit_len = st_q.cnt;
    assign mem_addr   = st_q.cnt[ADDR_W-1:0];
    assign mem_wdata  = rx_byte;
    assign ovf_flag   = st_q.ovf;
endmodule

// File: rtl/bop_rd_ctrl.sv
// Read side: pointer into the oldest committed slot and release on last byte.
module bop_rd_ctrl #(
    parameter int DEPTH = 64,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_pop,
    input  logic              cur_full,
    input  logic [CNT_W-1:0]  cur_len,
    output logic              rd_sel,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rel_pulse,
    output logic              byte_valid,
    output logic [CNT_W-1:0]  remain
);
    localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

    typedef struct packed {
        logic             sel;
        logic [CNT_W-1:0] ptr;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic [CNT_W-1:0] ptr_inc;

    always_comb begin
        st_d      = st_q;
        ptr_inc   = st_q.ptr + ONE_CNT;
        rel_pulse = 1'b0;
        if (rd_pop && cur_full) begin
            if (ptr_inc >= cur_len) begin
                rel_pulse = 1'b1;
                st_d.ptr  = '0;
                st_d.sel  = ~st_q.sel;
            end else begin
                st_d.ptr = ptr_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_sel     = st_q.sel;
    assign rd_addr    = st_q.ptr[ADDR_W-1:0];
    assign byte_valid = cur_full && (st_q.ptr < cur_len);
    assign remain     = cur_full ? (cur_len - st_q.ptr) : '0;
endmodule

// File: rtl/bop_slot_track.sv
// Occupancy and committed length of each slot.
module bop_slot_track #(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int NS    = bop_pkg::NUM_SLOTS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   claim,
    input  logic                   commit,
    input  logic                   drop,
    input  logic                   wr_sel,
    input  logic [CNT_W-1:0]       commit_len,
    input  logic                   rel_pulse,
    input  logic                   rd_sel,
    output logic [NS-1:0]          slot_free,
    output logic [NS-1:0]          slot_full,
    output logic [NS-1:0][CNT_W-1:0] slot_len
);
    import bop_pkg::*;

    typedef struct packed {
        slot_state_e [NS-1:0]     st;
        logic [NS-1:0][CNT_W-1:0] len;
    } track_t;

    track_t tr_d, tr_q;

    always_comb begin
        tr_d = tr_q;
        for (int i = 0; i < NS; i++) begin
            if (wr_sel == i[0]) begin
                if (claim) begin
                    tr_d.st[i] = SLOT_FILL;
                end else if (commit) begin
                    tr_d.st[i]  = SLOT_FULL;
                    tr_d.len[i] = commit_len;
                end else if (drop) begin
                    tr_d.st[i] = SLOT_FREE;
                end
            end
            if (rel_pulse && (rd_sel == i[0])) begin
                tr_d.st[i]  = SLOT_FREE;
                tr_d.len[i] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tr_q <= '0;
        end else begin
            tr_q <= tr_d;
        end
    end

    for (genvar g = 0; g < NS; g++) begin : g_flags
        assign slot_free[g] = (tr_q.st[g] == SLOT_FREE);
        assign slot_full[g] = (tr_q.st[g] == SLOT_FULL);
        assign slot_len[g]  = tr_q.len[g];
    end
endmodule

// File: rtl/bulk_out_pingpong.sv
// Two-slot ping-pong receive buffer for a bulk OUT endpoint.
module bulk_out_pingpong #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         svc_dma_sel,
    input  logic                         tok_out,
    output logic                         tok_ack,
    output logic                         tok_nak,
    input  logic                         rx_wr,
    input  logic [DATA_W-1:0]            rx_byte,
    input  logic                         rx_eop,
    input  logic                         rx_abort,
    input  logic                         rd_pop,
    output logic [DATA_W-1:0]            rd_byte,
    output logic [$clog2(DEPTH+1)-1:0]   rd_remain,
    output logic                         pkt_avail,
    output logic                         irq,
    output logic                         dma_req,
    output logic                         ovf_flag
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int NS     = bop_pkg::NUM_SLOTS;

    logic                     wr_sel, claim, commit, drop;
    logic [CNT_W-1:0]         commit_len;
    logic                     mem_we;
    logic [ADDR_W-1:0]        mem_addr;
    logic [DATA_W-1:0]        mem_wdata;
    logic                     rd_sel, rel_pulse, byte_valid;
    logic [ADDR_W-1:0]        rd_addr;
    logic [NS-1:0]            slot_free, slot_full;
    logic [NS-1:0][CNT_W-1:0] slot_len;
    logic [NS-1:0][DATA_W-1:0] slot_rd;
    logic                     tgt_free, cur_full;
    logic [CNT_W-1:0]         cur_len;

    assign tgt_free = slot_free[wr_sel];
    assign cur_full = slot_full[rd_sel];
    assign cur_len  = slot_len[rd_sel];

    bop_rx_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .tok_out    (tok_out),
        .rx_wr      (rx_wr),
        .rx_byte    (rx_byte),
        .rx_eop     (rx_eop),
        .rx_abort   (rx_abort),
        .tgt_free   (tgt_free),
        .tok_ack    (tok_ack),
        .tok_nak    (tok_nak),
        .wr_sel     (wr_sel),
        .claim      (claim),
        .commit     (commit),
        .drop       (drop),
        .commit_len (commit_len),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .ovf_flag   (ovf_flag)
    );

    bop_slot_track #(.DEPTH(DEPTH)) u_track (
        .clk        (clk),
        .rst        (rst),
        .claim      (claim),
        .commit     (commit),
        .drop       (drop),
        .wr_sel     (wr_sel),
        .commit_len (commit_len),
        .rel_pulse  (rel_pulse),
        .rd_sel     (rd_sel),
        .slot_free  (slot_free),
        .slot_full  (slot_full),
        .slot_len   (slot_len)
    );

    bop_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .rd_pop     (rd_pop),
        .cur_full   (cur_full),
        .cur_len    (cur_len),
        .rd_sel     (rd_sel),
        .rd_addr    (rd_addr),
        .rel_pulse  (rel_pulse),
        .byte_valid (byte_valid),
        .remain     (rd_remain)
    );

    for (genvar g = 0; g < NS; g++) begin : g_slot
        bop_slot_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
            .clk     (clk),
            .wr_en   (mem_we && (wr_sel == g[0])),
            .wr_addr (mem_addr),
            .wr_data (mem_wdata),
            .rd_addr (rd_addr),
            .rd_data (slot_rd[g])
        );
    end

    assign rd_byte   = byte_valid ? slot_rd[rd_sel] : '0;
    assign pkt_avail = cur_full;
    assign irq       = cur_full && !svc_dma_sel;
    assign dma_req   = cur_full && svc_dma_sel;
endmodule

// File: rtl/bop_checker.sv
module bop_checker #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              svc_dma_sel,
    input logic              tok_out,
    input logic              tok_ack,
    input logic              tok_nak,
    input logic              rd_pop,
    input logic [DATA_W-1:0] rd_byte,
    input logic [CNT_W-1:0]  rd_remain,
    input logic              pkt_avail,
    input logic              irq,
    input logic              dma_req,
    input logic              ovf_flag,
    input logic [1:0]        slots_full
);
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!pkt_avail && !ovf_flag && rd_byte == '0 && rd_remain == '0)); // R1
    AST_TOKEN_ONE_ANSWER: assert property (@(posedge clk) disable iff (rst) tok_out |-> (tok_ack != tok_nak)); // R2
    AST_NAK_WHEN_FULL: assert property (@(posedge clk) disable iff (rst) (tok_out && (&slots_full)) |-> tok_nak); // R3
    AST_SVC_FOLLOWS_AVAIL: assert property (@(posedge clk) disable iff (rst) (irq || dma_req) == pkt_avail); // R4
    AST_SVC_ROUTE: assert property (@(posedge clk) disable iff (rst) svc_dma_sel |-> !irq); // R5
    AST_AVAIL_HOLD: assert property (@(posedge clk) disable iff (rst) (pkt_avail && !rd_pop) |=> pkt_avail); // R7
    AST_REMAIN_BOUND: assert property (@(posedge clk) disable iff (rst) rd_remain <= CNT_W'(DEPTH)); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) ovf_flag |=> ovf_flag); // R8
    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (rst) !pkt_avail |-> (rd_byte == '0 && rd_remain == '0)); // R10
endmodule

bind bulk_out_pingpong bop_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_bop_chk (
    .clk         (clk),
    .rst         (rst),
    .svc_dma_sel (svc_dma_sel),
    .tok_out     (tok_out),
    .tok_ack     (tok_ack),
    .tok_nak     (tok_nak),
    .rd_pop      (rd_pop),
    .rd_byte     (rd_byte),
    .rd_remain   (rd_remain),
    .pkt_avail   (pkt_avail),
    .irq         (irq),
    .dma_req     (dma_req),
    .ovf_flag    (ovf_flag),
    .slots_full  (slot_full)
);

// File: tb/bulk_out_pingpong_bench.sv
module bulk_out_pingpong_bench;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       svc_dma_sel = 1'b0;
    logic       tok_out = 1'b0;
    logic       tok_ack, tok_nak;
    logic       rx_wr = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_eop = 1'b0;
    logic       rx_abort = 1'b0;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_byte;
    logic [6:0] rd_remain;
    logic       pkt_avail, irq, dma_req, ovf_flag;

    always #5 clk = ~clk;

    bulk_out_pingpong u_bulk_out_pingpong (
        .clk(clk), .rst(rst), .svc_dma_sel(svc_dma_sel),
        .tok_out(tok_out), .tok_ack(tok_ack), .tok_nak(tok_nak),
        .rx_wr(rx_wr), .rx_byte(rx_byte), .rx_eop(rx_eop), .rx_abort(rx_abort),
        .rd_pop(rd_pop), .rd_byte(rd_byte), .rd_remain(rd_remain),
        .pkt_avail(pkt_avail), .irq(irq), .dma_req(dma_req), .ovf_flag(ovf_flag)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model
    logic [7:0] m_mem [2][DEPTH];
    int  m_len [2];
    int  m_head = 0;
    int  m_cnt = 0;
    int  m_ptr = 0;
    bit  m_ovf = 1'b0;
    logic [7:0] pk [128];

    task automatic chk_eq(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_remain();
        return (m_cnt > 0) ? (m_len[m_head] - m_ptr) : 0;
    endfunction

    function automatic int exp_byte();
        if (m_cnt > 0 && m_ptr < m_len[m_head]) return int'(m_mem[m_head][m_ptr]);
        return 0;
    endfunction

    task automatic model_commit(int len);
        int s = (m_head + m_cnt) % 2;
        for (int i = 0; i < len; i++) m_mem[s][i] = pk[i];
        m_len[s] = len;
        m_cnt++;
    endtask

    task automatic model_pop();
        if (m_cnt > 0) begin
            m_ptr++;
            if (m_ptr >= m_len[m_head]) begin
                m_ptr = 0;
                m_head ^= 1;
                m_cnt--;
            end
        end
    endtask

    task automatic check_status(string req);
        chk_eq({req, " pkt_avail"}, int'(pkt_avail), int'(m_cnt > 0));
        chk_eq({req, " irq"}, int'(irq), int'(m_cnt > 0 && !svc_dma_sel));
        chk_eq({req, " dma_req"}, int'(dma_req), int'(m_cnt > 0 && svc_dma_sel));
        chk_eq({req, " ovf_flag"}, int'(ovf_flag), int'(m_ovf));
        chk_eq({req, " rd_remain"}, int'(rd_remain), exp_remain());
        chk_eq({req, " rd_byte"}, int'(rd_byte), exp_byte());
    endtask

    // all tasks start and end at a falling edge
    task automatic send_pkt(int len, bit abort, string req);
        bit exp_ack = (m_cnt < 2);
        tok_out = 1'b1;
        #1;
        chk_eq(exp_ack ? "R2 tok_ack" : "R3 tok_ack", int'(tok_ack), int'(exp_ack));
        chk_eq(exp_ack ? "R2 tok_nak" : "R3 tok_nak", int'(tok_nak), int'(!exp_ack));
        @(posedge clk); @(negedge clk);
        tok_out = 1'b0;
        for (int i = 0; i < len; i++) begin
            pk[i] = 8'($urandom);
            rx_wr = 1'b1;
            rx_byte = pk[i];
            @(posedge clk); @(negedge clk);
        end
        rx_wr = 1'b0;
        if (abort) rx_abort = 1'b1; else rx_eop = 1'b1;
        @(posedge clk); @(negedge clk);
        rx_abort = 1'b0;
        rx_eop = 1'b0;
        if (exp_ack && len > DEPTH) m_ovf = 1'b1;
        else if (exp_ack && !abort) model_commit(len);
        #1;
        check_status(req);
    endtask

    task automatic pop_n(int n, string req);
        for (int i = 0; i < n; i++) begin
            rd_pop = 1'b1;
            #1;
            chk_eq({req, " R6 rd_byte"}, int'(rd_byte), exp_byte());
            chk_eq({req, " R7 rd_remain"}, int'(rd_remain), exp_remain());
            @(posedge clk); @(negedge clk);
            rd_pop = 1'b0;
            model_pop();
        end
        #1;
        check_status(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check_status("R1");

        // R10: pop on empty leaves pointers untouched
        pop_n(3, "R10");

        // R11: receive strobes with no accepted token
        rx_wr = 1'b1; rx_byte = 8'h5a;
        @(posedge clk); @(negedge clk);
        rx_wr = 1'b0; rx_eop = 1'b1;
        @(posedge clk); @(negedge clk);
        rx_eop = 1'b0; rx_abort = 1'b1;
        @(posedge clk); @(negedge clk);
        rx_abort = 1'b0;
        #1;
        check_status("R11");

        // R4/R5: interrupt routing, then fill both slots
        send_pkt(5, 1'b0, "R4 R5 irq");
        send_pkt(DEPTH, 1'b0, "R4 full-size");
        // R3: both slots committed -> NAK, bytes after NAK ignored (R11)
        send_pkt(7, 1'b0, "R3 R11 nak");
        pop_n(1, "R7 partial");
        send_pkt(2, 1'b0, "R3 nak persists");
        pop_n(4, "R7 release first");
        chk_eq("R7 remain second", int'(rd_remain), DEPTH);
        send_pkt(9, 1'b0, "R2 ack after release");
        // R5: switch to DMA routing
        svc_dma_sel = 1'b1;
        #1;
        check_status("R5 dma");
        pop_n(DEPTH + 9, "R6 order");
        pop_n(2, "R10 drained");

        // R8: oversize packet
        send_pkt(DEPTH + 4, 1'b0, "R8 overflow");
        send_pkt(3, 1'b0, "R8 sticky");
        // R9: abort then new packet
        send_pkt(6, 1'b1, "R9 abort");
        send_pkt(4, 1'b0, "R9 after abort");
        svc_dma_sel = 1'b0;
        pop_n(7, "R6 R9 drain");
        // R7: zero-length packet
        send_pkt(0, 1'b0, "R7 zero-len");
        pop_n(1, "R7 zero-len release");

        // random mix
        for (int it = 0; it < 300; it++) begin
            int act = int'($urandom_range(0, 9));
            if (act < 4) begin
                int l = int'($urandom_range(0, 20));
                if (l == 0) l = 0;
                else if (l == 1) l = DEPTH;
                else if (l == 2) l = DEPTH + 1;
                else l = int'($urandom_range(1, DEPTH));
                send_pkt(l, 1'b0, "R2 R3 R4 rand pkt");
            end else if (act == 4) begin
                send_pkt(int'($urandom_range(0, 10)), 1'b1, "R9 rand abort");
            end else if (act == 5) begin
                svc_dma_sel = 1'($urandom);
                #1;
                check_status("R5 rand route");
            end else begin
                pop_n(int'($urandom_range(1, 40)), "R6 rand pop");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule